// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns three supply-comparator flags into the control actions that keep a processor and its memory safe while the supply sags, fails and comes back. The flags, in rising order of severity, say that the supply is below the warning level, below the minimum operating level, or below the level at which the backup battery must take over. The comparators themselves sit outside the block. Here they appear as asynchronous digital inputs. Each flag is synchronized and then debounced before the sequencer acts on it.

The sequencer has five states. NORMAL (code 0) is the healthy state. WARN (code 1) means the supply is low but the processor keeps running. RESET (code 2) holds the processor in reset. BACKUP (code 3) selects the battery and shuts down everything except retention logic. POR_DELAY (code 4) counts a fixed number of clocks after recovery before reset is released.

The transitions are:
- fall-warn: NORMAL to WARN, which raises a one-cycle interrupt request with vector 0x2B if the warning is enabled.
- rise-warn: WARN to NORMAL.
- fall-min: NORMAL, WARN or POR_DELAY to RESET.
- fall-bat: any state to BACKUP.
- bat-clear: BACKUP to RESET, or to POR_DELAY if the minimum flag is also clear.
- min-clear: RESET to POR_DELAY.
- por-done: POR_DELAY to NORMAL, or to WARN if the warning flag is still set.

While the processor is held in reset, the memory chip enables and the read/write strobe are forced to their inactive high level.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: Each comparator input passes through a two-flop synchronizer. A change on a synchronized flag is accepted only after it has held for FILT_CYCLES consecutive cycles. A pulse shorter than that leaves the state unchanged.
- R2: On the fall-warn transition with `warn_en`=1, `warn_irq` is high for exactly one cycle: the first cycle in which `state_o` reads WARN. `irq_vector` always reads 0x2B.
- R3: With `warn_en`=0, fall-warn still moves the state to WARN, but no `warn_irq` pulse is produced.
- R4: In NORMAL and WARN, `cpu_reset` is 0, so the processor keeps running.
- R5: `warn_irq` fires only on NORMAL→WARN. It does not fire again until the state has returned to NORMAL, and it never fires on por-done into WARN.
- R6: A filtered minimum flag moves NORMAL, WARN or POR_DELAY to RESET. `cpu_reset` is 1 in RESET, BACKUP and POR_DELAY.
- R7: Whenever `cpu_reset` is 1, every bit of `ce_n_out` and `rw_n_out` is 1. Otherwise these outputs follow `ce_n_in` and `rw_n_in`.
- R8: A filtered battery flag moves any state to BACKUP. `bat_sel` and `core_off` are 1 exactly in BACKUP.
- R9: When flags are set together, the most severe one decides the next state, in the order battery, then minimum, then warning.
- R10: POR_DELAY lasts exactly POR_CYCLES cycles (21504 by default). It then goes to NORMAL, or to WARN if the warning flag is set. A new minimum or battery flag aborts POR_DELAY.
- R11: While `rst_n` is low, the state is POR_DELAY with an empty count. After release, `cpu_reset` stays 1 for POR_CYCLES cycles.
- R12: `state_o` encodes NORMAL=0, WARN=1, RESET=2, BACKUP=3, POR_DELAY=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_en | input | 1 | Warning interrupt enable bit |
| below_warn_a | input | 1 | Asynchronous flag: supply below warning level |
| below_min_a | input | 1 | Asynchronous flag: supply below minimum operating level |
| below_bat_a | input | 1 | Asynchronous flag: supply below battery switch level |
| ce_n_in | input | N_CE | Decoded active-low chip enables from the memory decoder |
| rw_n_in | input | 1 | Read/write strobe from the processor |
| ce_n_out | output | N_CE | Chip enables after the reset override |
| rw_n_out | output | 1 | Read/write strobe after the reset override |
| warn_irq | output | 1 | One-cycle warning interrupt request |
| irq_vector | output | 8 | Vector address of the warning interrupt (0x2B) |
| cpu_reset | output | 1 | Processor reset, active high |
| bat_sel | output | 1 | Selects the battery as supply source |
| core_off | output | 1 | Disables all logic except retention |
| state_o | output | 3 | Current sequencer state code |

## Verification
The bench goes after four corner cases.
- Chatter on the warning flag after the first crossing. A design without a working filter, or one that re-arms the interrupt too early, would raise extra interrupt pulses.
- An abort of POR_DELAY by a fresh minimum drop, followed by a full restart. A timer that is not cleared would release reset early.
- All three flags rising together, then clearing one at a time. This exposes a wrong severity order, or a BACKUP exit that skips RESET.
- Recovery with the warning flag still set. A design that treated por-done like fall-warn would raise a spurious interrupt.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        PS_NORMAL = 3'd0,
        PS_WARN   = 3'd1,
        PS_RESET  = 3'd2,
        PS_BACKUP = 3'd3,
        PS_POR    = 3'd4
    } pfs_state_e;

    localparam logic [7:0] PFS_IRQ_VECTOR = 8'h2B;

    // flag indices inside the conditioned flag vector
    localparam int FLG_WARN = 0;
    localparam int FLG_MIN  = 1;
    localparam int FLG_BAT  = 2;
    localparam int FLG_NUM  = 3;

endpackage

// File: rtl/pfs_flag_filter.sv
module pfs_flag_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_a,
    output logic flag_f
);
    localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] hold_q;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= flag_a;
            sync_q <= meta_q;
        end
    end

    // accept a new level only after it has held FILT_CYCLES cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_f <= 1'b0;
            hold_q <= '0;
        end else if (sync_q == flag_f) begin
            hold_q <= '0;
        end else if (hold_q == CW'(FILT_CYCLES - 1)) begin
            flag_f <= sync_q;
            hold_q <= '0;
        end else begin
            hold_q <= hold_q + 1'b1;
        end
    end
endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
    parameter int POR_CYCLES = 21504
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(POR_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign done = run && (cnt_q == CW'(POR_CYCLES - 1));
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       f_warn,
    input  logic       f_min,
    input  logic       f_bat,
    input  logic       por_done,
    input  logic       warn_en,
    output pfs_state_e state_q,
    output logic       warn_irq,
    output logic       cpu_reset,
    output logic       bat_sel,
    output logic       core_off
);
    pfs_state_e state_d;

    // next state, most severe flag first
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_NORMAL, PS_WARN: begin
                if (f_bat)       state_d = PS_BACKUP;
                else if (f_min)  state_d = PS_RESET;
                else if (f_warn) state_d = PS_WARN;
                else             state_d = PS_NORMAL;
            end
            PS_RESET, PS_BACKUP: begin
                if (f_bat)       state_d = PS_BACKUP;
                else if (f_min)  state_d = PS_RESET;
                else             state_d = PS_POR;
            end
            PS_POR: begin
                if (f_bat)         state_d = PS_BACKUP;
                else if (f_min)    state_d = PS_RESET;
                else if (por_done) state_d = f_warn ? PS_WARN : PS_NORMAL;
                else               state_d = PS_POR;
            end
            default: state_d = PS_POR;
        endcase
    end

    // state register and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_POR;
            warn_irq <= 1'b0;
        end else begin
            state_q  <= state_d;
            warn_irq <= warn_en && (state_q == PS_NORMAL) && (state_d == PS_WARN);
        end
    end

    // outputs decoded from state
    always_comb begin
        cpu_reset = 1'b0;
        bat_sel   = 1'b0;
        core_off  = 1'b0;
        unique case (state_q)
            PS_NORMAL, PS_WARN: cpu_reset = 1'b0;
            PS_RESET, PS_POR:   cpu_reset = 1'b1;
            PS_BACKUP: begin
                cpu_reset = 1'b1;
                bat_sel   = 1'b1;
                core_off  = 1'b1;
            end
            default:            cpu_reset = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor
    import pfs_pkg::*;
#(
    parameter int FILT_CYCLES = 4,
    parameter int POR_CYCLES  = 21504,
    parameter int N_CE        = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            warn_en,
    input  logic            below_warn_a,
    input  logic            below_min_a,
    input  logic            below_bat_a,
    input  logic [N_CE-1:0] ce_n_in,
    input  logic            rw_n_in,
    output logic [N_CE-1:0] ce_n_out,
    output logic            rw_n_out,
    output logic            warn_irq,
    output logic [7:0]      irq_vector,
    output logic            cpu_reset,
    output logic            bat_sel,
    output logic            core_off,
    output logic [2:0]      state_o
);
    logic [FLG_NUM-1:0] flags_a;
    logic [FLG_NUM-1:0] flags_f;
    logic               por_done;
    pfs_state_e         state_q;

    assign flags_a[FLG_WARN] = below_warn_a;
    assign flags_a[FLG_MIN]  = below_min_a;
    assign flags_a[FLG_BAT]  = below_bat_a;

    for (genvar g = 0; g < FLG_NUM; g++) begin : g_flag
        pfs_flag_filter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .flag_a (flags_a[g]),
            .flag_f (flags_f[g])
        );
    end

    pfs_por_timer #(.POR_CYCLES(POR_CYCLES)) por_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == PS_POR),
        .done  (por_done)
    );

    pfs_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .f_warn    (flags_f[FLG_WARN]),
        .f_min     (flags_f[FLG_MIN]),
        .f_bat     (flags_f[FLG_BAT]),
        .por_done  (por_done),
        .warn_en   (warn_en),
        .state_q   (state_q),
        .warn_irq  (warn_irq),
        .cpu_reset (cpu_reset),
        .bat_sel   (bat_sel),
        .core_off  (core_off)
    );

    // bus override during reset
    assign ce_n_out   = cpu_reset ? '1 : ce_n_in;
    assign rw_n_out   = cpu_reset | rw_n_in;
    assign irq_vector = PFS_IRQ_VECTOR;
    assign state_o    = state_q;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int POR_CYCLES = 21504,
    parameter int N_CE       = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CE-1:0] ce_n_out,
    input logic            rw_n_out,
    input logic            warn_irq,
    input logic [7:0]      irq_vector,
    input logic            cpu_reset,
    input logic            bat_sel,
    input logic            core_off,
    input logic [2:0]      state_o
);
    int unsigned por_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               por_len <= 0;
        else if (state_o == 3'd4) por_len <= por_len + 1;
        else                      por_len <= 0;
    end

    a_r12_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    a_r7_bus_forced: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset |-> (&ce_n_out && rw_n_out));

    a_r8_bat_only_backup: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sel || core_off) |-> (state_o == 3'd3));

    a_r4_run_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o <= 3'd1) |-> !cpu_reset);

    a_r2_irq_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> (state_o == 3'd1 && $past(state_o) == 3'd0 && irq_vector == 8'h2B));

    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |=> !warn_irq);

    a_r10_por_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd4 && state_o <= 3'd1) |-> (por_len == POR_CYCLES));
endmodule

bind pwr_fail_supervisor pfs_checker #(.POR_CYCLES(POR_CYCLES), .N_CE(N_CE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n_out   (ce_n_out),
    .rw_n_out   (rw_n_out),
    .warn_irq   (warn_irq),
    .irq_vector (irq_vector),
    .cpu_reset  (cpu_reset),
    .bat_sel    (bat_sel),
    .core_off   (core_off),
    .state_o    (state_o)
);

// File: tb/pwr_fail_supervisor_tb_top.sv
module pwr_fail_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 4;
    localparam int PORC = 21504;
    localparam int NCE  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           warn_en = 1'b1;
    logic           b_warn = 1'b0, b_min = 1'b0, b_bat = 1'b0;
    logic [NCE-1:0] ce_n_in = '1;
    logic           rw_n_in = 1'b1;
    logic [NCE-1:0] ce_n_out;
    logic           rw_n_out, warn_irq, cpu_reset, bat_sel, core_off;
    logic [7:0]     irq_vector;
    logic [2:0]     state_o;

    int tests = 0;
    int fails = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_fail_supervisor #(.FILT_CYCLES(FILT), .POR_CYCLES(PORC), .N_CE(NCE)) dut_i (
        .clk(clk), .rst_n(rst_n), .warn_en(warn_en),
        .below_warn_a(b_warn), .below_min_a(b_min), .below_bat_a(b_bat),
        .ce_n_in(ce_n_in), .rw_n_in(rw_n_in),
        .ce_n_out(ce_n_out), .rw_n_out(rw_n_out), .warn_irq(warn_irq),
        .irq_vector(irq_vector), .cpu_reset(cpu_reset), .bat_sel(bat_sel),
        .core_off(core_off), .state_o(state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_pipe1[3], m_pipe2[3], m_lvl[3], m_run[3];
    int  m_st, m_age, m_irq;
    bit  m_ok = 1'b0;

    always @(posedge clk) begin
        int raw[3];
        int nst;
        raw[0] = b_warn; raw[1] = b_min; raw[2] = b_bat;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_pipe1[i] = 0; m_pipe2[i] = 0; m_lvl[i] = 0; m_run[i] = 0;
            end
            m_st = 4; m_age = 0; m_irq = 0;
        end else begin
            // severity: battery, then minimum, then warning (R9)
            if (m_lvl[2] != 0)       nst = 3;
            else if (m_lvl[1] != 0)  nst = 2;
            else if (m_st == 2 || m_st == 3) nst = 4;
            else if (m_st == 4)      nst = (m_age == PORC-1) ? (m_lvl[0] != 0 ? 1 : 0) : 4;
            else                     nst = (m_lvl[0] != 0) ? 1 : 0;
            m_irq = (m_st == 0 && nst == 1 && warn_en) ? 1 : 0;
            m_age = (m_st == 4) ? m_age + 1 : 0;
            m_st  = nst;
            for (int i = 0; i < 3; i++) begin
                if (m_pipe2[i] == m_lvl[i]) m_run[i] = 0;
                else if (m_run[i] == FILT-1) begin m_lvl[i] = m_pipe2[i]; m_run[i] = 0; end
                else m_run[i]++;
                m_pipe2[i] = m_pipe1[i];
                m_pipe1[i] = raw[i];
            end
        end
        m_ok = 1'b1;
    end

    // compare every cycle away from the edge
    always @(negedge clk) begin
        if (m_ok && !done) begin
            int rs;
            rs = (m_st >= 2) ? 1 : 0;
            chk("R12 state", state_o, m_st);
            chk("R6 cpu_reset", cpu_reset, rs);
            chk("R7 bus override", {ce_n_out, rw_n_out},
                rs ? {NCE+1{1'b1}} : {ce_n_in, rw_n_in});
            chk("R8 battery outputs", {bat_sel, core_off}, (m_st == 3) ? 3 : 0);
            chk("R2 warn_irq", warn_irq, m_irq);
            chk("R2 irq_vector", irq_vector, 8'h2B);
            if (warn_irq) irq_seen++;
        end
    end

    // bus activity pattern
    always begin
        @(posedge clk); #2;
        {ce_n_in, rw_n_in} = {ce_n_in, rw_n_in} + 5'd7;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic count_por(output int n);
        n = 0;
        @(negedge clk);
        while (state_o != 3'd4) @(negedge clk);
        while (state_o == 3'd4) begin n++; @(negedge clk); end
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; tests++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int n, base;
        tick(3);
        chk("R11 reset state", state_o, 4);
        chk("R11 reset cpu_reset", cpu_reset, 1);
        rst_n = 1'b1;
        count_por(n);
        chk("R11 release delay", n, PORC);

        // R2/R5: warning drop with chatter
        base = irq_seen;
        b_warn = 1; tick(20);
        chk("R4 run in warn", cpu_reset, 0);
        for (int k = 0; k < 5; k++) begin b_warn = 0; tick(2); b_warn = 1; tick(3); end
        tick(10);
        chk("R5 one irq per crossing", irq_seen - base, 1);
        // R1: short glitch back up does not leave WARN
        chk("R1 glitch ignored", state_o, 1);
        b_warn = 0; tick(20);
        b_warn = 1; tick(20);
        chk("R5 re-armed after NORMAL", irq_seen - base, 2);
        b_warn = 0; tick(20);

        // R3: disabled warning
        warn_en = 0; base = irq_seen;
        b_warn = 1; tick(20);
        chk("R3 state WARN without irq", state_o, 1);
        chk("R3 no irq", irq_seen - base, 0);
        b_warn = 0; tick(20); warn_en = 1;

        // R1: short min glitch
        b_min = 1; tick(2); b_min = 0; tick(15);
        chk("R1 min glitch ignored", state_o, 0);

        // R6/R10: min drop, recovery, abort, full POR with warn held
        b_warn = 1; b_min = 1; tick(20);
        chk("R6 reset on min", state_o, 2);
        base = irq_seen;
        b_min = 0; tick(200);
        chk("R10 in POR", state_o, 4);
        b_min = 1; tick(20);
        chk("R10 POR aborted", state_o, 2);
        b_min = 0;
        count_por(n);
        chk("R10 full delay after abort", n, PORC);
        chk("R10 ends in WARN", state_o, 1);
        chk("R5 no irq on recovery", irq_seen - base, 0);
        b_warn = 0; tick(20);

        // R9/R8: all flags together, then peel off
        b_warn = 1; b_min = 1; b_bat = 1; tick(20);
        chk("R9 battery wins", state_o, 3);
        chk("R8 bat_sel", bat_sel, 1);
        b_bat = 0; tick(20);
        chk("R9 back to RESET", state_o, 2);
        b_min = 0; tick(100);
        b_bat = 1; tick(20);
        chk("R10 POR aborted by battery", state_o, 3);
        b_bat = 0; b_warn = 0;
        count_por(n);
        chk("R10 delay after backup", n, PORC);
        chk("R10 ends in NORMAL", state_o, 0);
        tick(5);
        finish_up();
    end
endmodule